// File: doc/BRIEF.md
# GMSK Baseband I/Q Modulator

This block converts a serial stream of transmit bits into signed in-phase (I) and quadrature (Q) sample words. Each bit first passes through a differential precoder. The precoded symbols then drive a frequency pulse that spans four bit periods. The phase change for every sample is read from a table. The table is addressed by the last four symbols and by the sample's position inside the bit. A running carrier phase accumulates these changes, and a quarter-wave table with quadrant folding turns the phase into cosine and sine amplitudes.

The surrounding logic pulses `bitStb` with the new bit on `bitIn` once per bit period. It then pulses `smpEn` sixteen times, at any spacing, to draw the samples of that bit. A synchronous `idleReq` puts the modulator into its quiet state. That state is the one reached after an endless run of ones: the carrier phase is zero, every remembered symbol is +1 and the previous raw bit is 1. Transmission restarts cleanly from there.

Top module: `gmsk_iq_mod`

## Requirements
- R1: After `rstN` is low, `outValid`, `iOut` and `qOut` are 0. The modulator starts in the all-ones state: phase 0, four +1 symbols, previous bit 1. From that state, a bit value 1 followed by its 16 samples ends at phase 2^16, so the last sample gives I = 0 and Q = 510.
- R2: Each strobed bit b is precoded as d = b XOR (previous raw bit). d = 0 becomes symbol +1, which moves the phase forward, and d = 1 becomes symbol -1.
- R3: Each `bitStb` opens a window of exactly 16 samples. Further `smpEn` pulses before the next `bitStb` produce nothing. After reset or idle, no sample is produced until the first `bitStb`.
- R4: The phase step of sample k (0..15) is the sum over j = 0..3 of a_j * g(16j + k). Here a_0 is the newest symbol, and g(t) for t in 0..63 is defined through u = min(t, 63 - t): g = (2u+1)^2 when u < 16, and g = 2048 - (63 - 2u)^2 otherwise.
- R5: The phase is an 18-bit unsigned accumulator in which 2^18 is one full turn and which wraps modulo 2^18. A bit whose four symbols are all the same moves the phase by exactly ±2^16 (a quarter turn).
- R6: With q = phase[17:16] and n = phase[15:10], the output angle is (64q + n) * 360/256 degrees. `iOut` and `qOut` are two's-complement values within 1 LSB of round(510*cos) and round(510*sin) of that angle, and they never exceed ±510.
- R7: A `smpEn` accepted at a clock edge makes `outValid` high for one cycle after the second edge. `iOut` and `qOut` change only in cycles where `outValid` is high, and back-to-back `smpEn` pulses give back-to-back valid samples.
- R8: When `bitStb` and `smpEn` are both high in the same cycle, the bit is taken and the `smpEn` is ignored.
- R9: `idleReq` overrides every other input. In that cycle it returns the modulator to the all-ones state, cancels any sample still in flight, and leaves `iOut` and `qOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| idleReq | input | 1 | Synchronous return to the all-ones quiet state |
| bitStb | input | 1 | One-cycle strobe that takes a new bit |
| bitIn | input | 1 | Raw transmit bit, sampled with `bitStb` |
| smpEn | input | 1 | One-cycle request for the next sample of the current bit |
| iOut | output | 10 | In-phase sample, two's complement |
| qOut | output | 10 | Quadrature sample, two's complement |
| outValid | output | 1 | High for one cycle per new I/Q sample |

## Verification
An accepted `smpEn` updates the phase register at its edge, and the matching I/Q words and `outValid` appear after the next edge, two edges in all. A bit strobe or an idle request changes the state at its own edge but has no output of its own. The bench drives inputs at the falling edge and advances a behavioural model once per cycle: the model holds its symbols in an integer array and keeps the pending sample in a one-deep stage. The outputs are then compared at that same falling edge, so every expected value lines up with the two-edge delay.

// File: rtl/gmsk_pkg.sv
package gmsk_pkg;

  // Samples per bit = 2**SPB_LOG2; pulse span in bits.
  localparam int SPB_LOG2 = 4;
  localparam int SPB      = 1 << SPB_LOG2;
  localparam int SPAN     = 4;
  localparam int CNT_W    = SPB_LOG2 + 1;

  typedef struct packed {
    logic                advance;   // take one sample this cycle
    logic                clearAll;  // return to quiet state
    logic [SPAN-1:0]     hist;      // bit j set: symbol j is -1 (j=0 newest)
    logic [SPB_LOG2-1:0] subIdx;    // sample index inside the bit
  } ctrlStb_t;

  // Bell-shaped frequency pulse built from two mirrored parabolic segments.
  function automatic int pulseTap(input int t);
    int halfLen;
    int u;
    halfLen = (SPAN * SPB) / 2;
    u = (t < halfLen) ? t : (2 * halfLen - 1 - t);
    if (u < halfLen / 2) return (2 * u + 1) * (2 * u + 1);
    return 2 * halfLen * halfLen - (2 * (halfLen - 1 - u) + 1) * (2 * (halfLen - 1 - u) + 1);
  endfunction

  // Phase step for table address {hist, subIdx}.
  function automatic int phaseStep(input int addr);
    int k;
    int acc;
    k = addr % SPB;
    acc = 0;
    for (int j = 0; j < SPAN; j++) begin
      if (((addr >> (SPB_LOG2 + j)) & 1) != 0) acc -= pulseTap(j * SPB + k);
      else                                     acc += pulseTap(j * SPB + k);
    end
    return acc;
  endfunction

  // Quarter-wave magnitude: fullScale*sin(pi/2 * n/2**tabLog2), 7th-order series in Q16.
  function automatic int quarterSine(input int n, input int tabLog2, input int fullScale);
    longint x;
    longint x2;
    longint t;
    longint amp;
    x   = (longint'(n) << 16) >>> tabLog2;
    x2  = (x * x) >>> 16;
    t   = 64'sd307;
    t   = 64'sd5223   - ((t * x2) >>> 16);
    t   = 64'sd42334  - ((t * x2) >>> 16);
    t   = 64'sd102944 - ((t * x2) >>> 16);
    t   = (t * x) >>> 16;
    amp = (t * fullScale + 64'sd32768) >>> 16;
    if (amp > fullScale) amp = fullScale;
    if (amp < 0) amp = 0;
    return int'(amp);
  endfunction

endpackage

// File: rtl/gmsk_ctrl.sv
module gmsk_ctrl
  import gmsk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     idleReq,
  input  logic     bitStb,
  input  logic     bitIn,
  input  logic     smpEn,
  output ctrlStb_t stb
);

  logic             prevBit;
  logic [SPAN-1:0]  hist;
  logic [CNT_W-1:0] smpCnt;
  logic             windowDone;
  logic             takeSample;

  assign windowDone = smpCnt[CNT_W-1];
  assign takeSample = smpEn && !bitStb && !idleReq && !windowDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit <= 1'b1;
      hist    <= '0;
      smpCnt  <= CNT_W'(SPB);
    end else if (idleReq) begin
      prevBit <= 1'b1;
      hist    <= '0;
      smpCnt  <= CNT_W'(SPB);
    end else if (bitStb) begin
      prevBit <= bitIn;
      hist    <= {hist[SPAN-2:0], bitIn ^ prevBit};
      smpCnt  <= '0;
    end else if (takeSample) begin
      smpCnt  <= smpCnt + CNT_W'(1);
    end
  end

  always_comb begin
    stb.advance  = takeSample;
    stb.clearAll = idleReq;
    stb.hist     = hist;
    stb.subIdx   = smpCnt[SPB_LOG2-1:0];
  end

endmodule

// File: rtl/gmsk_datapath.sv
module gmsk_datapath
  import gmsk_pkg::*;
#(
  parameter int AMP_W      = 10,
  parameter int FULL_SCALE = 510,
  parameter int TAB_LOG2   = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStb_t                stb,
  output logic signed [AMP_W-1:0] iOut,
  output logic signed [AMP_W-1:0] qOut,
  output logic                    outValid
);

  localparam int QFRAC  = 3 * SPB_LOG2 + 4;     // bits per quarter turn
  localparam int PH_W   = QFRAC + 2;
  localparam int INC_W  = 2 * SPB_LOG2 + 6;
  localparam int ROM_D  = 1 << (SPAN + SPB_LOG2);
  localparam int ADDR_W = SPAN + SPB_LOG2;
  localparam int TAB_N  = 1 << TAB_LOG2;
  localparam int IDX_W  = TAB_LOG2 + 1;

  // Phase-step table, computed at elaboration.
  logic signed [INC_W-1:0] incRom [ROM_D];
  for (genvar a = 0; a < ROM_D; a++) begin : g_incRom
    localparam int STEP = phaseStep(a);
    assign incRom[a] = INC_W'(STEP);
  end

  // Quarter-wave amplitude table, one extra entry for the quadrant edge.
  logic [AMP_W-2:0] sinTab [TAB_N + 1];
  for (genvar n = 0; n <= TAB_N; n++) begin : g_sinTab
    localparam int MAG = quarterSine(n, TAB_LOG2, FULL_SCALE);
    assign sinTab[n] = (AMP_W - 1)'(MAG);
  end

  logic [ADDR_W-1:0]       romAddr;
  logic signed [INC_W-1:0] incSel;
  logic [PH_W-1:0]         phase;
  logic                    pending;

  assign romAddr = {stb.hist, stb.subIdx};
  assign incSel  = incRom[romAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      pending <= 1'b0;
    end else if (stb.clearAll) begin
      phase   <= '0;
      pending <= 1'b0;
    end else begin
      pending <= stb.advance;
      if (stb.advance)
        phase <= phase + {{(PH_W - INC_W){incSel[INC_W-1]}}, incSel};
    end
  end

  // Quadrant folding of the quarter wave.
  logic [1:0]              quad;
  logic [IDX_W-1:0]        sIdx;
  logic [IDX_W-1:0]        cIdx;
  logic signed [AMP_W-1:0] sPos;
  logic signed [AMP_W-1:0] cPos;
  logic signed [AMP_W-1:0] iNext;
  logic signed [AMP_W-1:0] qNext;

  assign quad = phase[PH_W-1 -: 2];
  assign sIdx = {1'b0, phase[QFRAC-1 -: TAB_LOG2]};
  assign cIdx = IDX_W'(TAB_N) - sIdx;
  assign sPos = {1'b0, sinTab[sIdx]};
  assign cPos = {1'b0, sinTab[cIdx]};

  always_comb begin
    unique case (quad)
      2'd0:    begin iNext = cPos;  qNext = sPos;  end
      2'd1:    begin iNext = -sPos; qNext = cPos;  end
      2'd2:    begin iNext = -cPos; qNext = -sPos; end
      default: begin iNext = sPos;  qNext = -cPos; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      iOut     <= '0;
      qOut     <= '0;
    end else begin
      outValid <= pending && !stb.clearAll;
      if (pending && !stb.clearAll) begin
        iOut <= iNext;
        qOut <= qNext;
      end
    end
  end

endmodule

// File: rtl/gmsk_iq_mod.sv
module gmsk_iq_mod
  import gmsk_pkg::*;
#(
  parameter int AMP_W      = 10,
  parameter int FULL_SCALE = 510,
  parameter int TAB_LOG2   = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    idleReq,
  input  logic                    bitStb,
  input  logic                    bitIn,
  input  logic                    smpEn,
  output logic signed [AMP_W-1:0] iOut,
  output logic signed [AMP_W-1:0] qOut,
  output logic                    outValid
);

  ctrlStb_t stb;

  gmsk_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .idleReq (idleReq),
    .bitStb  (bitStb),
    .bitIn   (bitIn),
    .smpEn   (smpEn),
    .stb     (stb)
  );

  gmsk_datapath #(
    .AMP_W      (AMP_W),
    .FULL_SCALE (FULL_SCALE),
    .TAB_LOG2   (TAB_LOG2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .iOut     (iOut),
    .qOut     (qOut),
    .outValid (outValid)
  );

endmodule

// File: rtl/gmsk_iq_mod_chk.sv
module gmsk_iq_mod_chk
  import gmsk_pkg::*;
#(
  parameter int AMP_W      = 10,
  parameter int FULL_SCALE = 510
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    idleReq,
  input logic                    bitStb,
  input logic                    smpEn,
  input logic                    outValid,
  input logic signed [AMP_W-1:0] iOut,
  input logic signed [AMP_W-1:0] qOut,
  input ctrlStb_t                stb
);

  logic [CNT_W:0] accCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  accCnt <= '0;
    else if (bitStb || idleReq) accCnt <= '0;
    else if (stb.advance)       accCnt <= accCnt + (CNT_W + 1)'(1);
  end

  // R3: at most one window of samples per bit
  p_sample_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    accCnt <= (CNT_W + 1)'(SPB));

  // R8: a bit strobe wins over a coincident sample request
  p_bit_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitStb |-> !stb.advance);

  // R7: a valid sample traces back to a request two edges earlier
  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(smpEn, 2));

  // R7: outputs hold between valid samples
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(iOut) && $stable(qOut)));

  // R9: idle request cancels the next output
  p_idle_kill_r9: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |=> !outValid);

  // R6: amplitudes stay inside full scale
  p_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (iOut <= AMP_W'(FULL_SCALE)) && (iOut >= -AMP_W'(FULL_SCALE)) &&
    (qOut <= AMP_W'(FULL_SCALE)) && (qOut >= -AMP_W'(FULL_SCALE)));

endmodule

bind gmsk_iq_mod gmsk_iq_mod_chk #(.AMP_W(AMP_W), .FULL_SCALE(FULL_SCALE)) u_chk (.*);

// File: tb/gmsk_iq_mod_bench.sv
module gmsk_iq_mod_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rstN = 1'b0, idleReq = 1'b0, bitStb = 1'b0, bitIn = 1'b0, smpEn = 1'b0;
  logic signed [9:0] iOut, qOut;
  logic outValid;

  gmsk_iq_mod u_gmsk_iq_mod (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .bitStb(bitStb), .bitIn(bitIn),
    .smpEn(smpEn), .iOut(iOut), .qOut(qOut), .outValid(outValid)
  );

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // Reference model state
  int mPrev, mCnt, mPhase, mPendV, mPendP, mOutV, mExpI, mExpQ;
  int mSym[4];

  function automatic int tap(input int t);
    int u = (t < 32) ? t : 63 - t;
    if (u < 16) return (2 * u + 1) * (2 * u + 1);
    return 2048 - (63 - 2 * u) * (63 - 2 * u);
  endfunction

  function automatic int ampOf(input int p, input bit useSin);
    int q = p >> 16;
    int n = (p >> 10) & 63;
    real ang = real'(q * 64 + n) * 6.283185307179586 / 256.0;
    real v = 510.0 * (useSin ? $sin(ang) : $cos(ang));
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    int diff = act - exp;
    checks++;
    if (diff > tol || diff < -tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic modelIdle();
    mPrev = 1; mCnt = 16; mPhase = 0; mPendV = 0; mPendP = 0; mOutV = 0;
    for (int j = 0; j < 4; j++) mSym[j] = 1;
  endtask

  task automatic modelStep();
    int inc;
    if (idleReq) begin
      modelIdle();   // R9
      return;
    end
    mOutV = mPendV;
    if (mPendV) begin
      mExpI = ampOf(mPendP, 1'b0);
      mExpQ = ampOf(mPendP, 1'b1);
    end
    mPendV = 0;
    if (bitStb) begin
      for (int j = 3; j > 0; j--) mSym[j] = mSym[j-1];
      mSym[0] = ((bitIn ? 1 : 0) ^ mPrev) != 0 ? -1 : 1;   // R2
      mPrev = bitIn ? 1 : 0;
      mCnt = 0;
    end else if (smpEn && mCnt < 16) begin
      inc = 0;
      for (int j = 0; j < 4; j++) inc += mSym[j] * tap(16 * j + mCnt);   // R4
      mPhase = (mPhase + inc) & 32'h3FFFF;                            // R5
      mPendP = mPhase;
      mPendV = 1;
      mCnt++;
    end
  endtask

  task automatic cyc(input bit bs, input bit b, input bit se, input bit idl);
    bitStb = bs; bitIn = b; smpEn = se; idleReq = idl;
    @(posedge clk);
    @(negedge clk);
    modelStep();
    check({tag, " valid"}, int'(outValid), mOutV, 0);
    check({tag, " I"}, int'(iOut), mExpI, 1);
    check({tag, " Q"}, int'(qOut), mExpQ, 1);
  endtask

  task automatic sendBit(input bit b, input int nSmp, input int maxGap);
    cyc(1'b1, b, 1'b0, 1'b0);
    for (int s = 0; s < nSmp; s++) begin
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      if (maxGap > 0) repeat ($urandom_range(maxGap, 0)) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    end
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modelIdle();
    mExpI = 0; mExpQ = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 reset valid", int'(outValid), 0, 0);
    check("R1 reset I", int'(iOut), 0, 0);
    check("R1 reset Q", int'(qOut), 0, 0);
    rstN = 1'b1;

    // R3: no samples before the first bit strobe
    tag = "R3";
    repeat (5) cyc(1'b0, 1'b0, 1'b1, 1'b0);

    // R1: first bit from the all-ones state lands on a quarter turn
    tag = "R1";
    sendBit(1'b1, 16, 0);
    check("R1 quarter I", int'(iOut), 0, 0);
    check("R1 quarter Q", int'(qOut), 510, 0);

    // R2: precoding with changing bits
    tag = "R2";
    sendBit(1'b0, 16, 0);
    sendBit(1'b1, 16, 0);
    sendBit(1'b0, 16, 0);
    sendBit(1'b0, 16, 0);
    sendBit(1'b1, 16, 0);

    // R4 / R6: random data with irregular sample spacing
    tag = "R4";
    for (int k = 0; k < 30; k++) sendBit(1'($urandom_range(1, 0)), 16, 2);
    tag = "R6";
    for (int k = 0; k < 20; k++) sendBit(1'($urandom_range(1, 0)), 16, 0);

    // R5: steady ones make the phase wrap more than once
    tag = "R5";
    for (int k = 0; k < 10; k++) sendBit(1'b1, 16, 0);

    // R3: surplus sample requests after the window
    tag = "R3";
    sendBit(1'b0, 22, 1);

    // R8: bit strobe coincident with a sample request
    tag = "R8";
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    for (int s = 0; s < 16; s++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 1'b0);

    // R7: single and back-to-back requests
    tag = "R7";
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 single pulse gone", int'(outValid), 0, 0);
    repeat (15) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 1'b0);

    // R9: idle request cancels an in-flight sample and restores the quiet state
    tag = "R9";
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 cancelled", int'(outValid), 0, 0);
    repeat (4) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    sendBit(1'b1, 16, 0);
    check("R9 restart I", int'(iOut), 0, 0);
    check("R9 restart Q", int'(qOut), 510, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule